// File: doc/BRIEF.md
# Timer with Compare and Edge Capture

This peripheral keeps a 19-bit free-running counter that advances by one on every clock. Software reads the counter as three byte registers. The split is uneven: the top eight bits, the middle eight bits, and the three lowest bits. A read of the top byte freezes the eleven lower bits in a snapshot. The following reads of the other two bytes therefore describe the same instant.

Four compare channels each hold a 16-bit value, which is matched against counter bits 18:3. Four capture inputs are synchronised and edge-detected, and they stamp counter bits 18:3 into capture registers. Inputs 0 and 1 each have two registers, one loaded on rising edges and one on falling edges. Inputs 2 and 3 each have a single register, and a control register chooses which edges load it.

Every compare match and every capture sets a sticky flag. Software clears a flag by writing 1 to its bit. The CPU reaches everything through a byte-wide register bus. The bus reads back combinationally and writes on the clock edge.

Top module: `tmr_cap_unit`

## Requirements
- R1: After reset the counter is 0 and increments by one every clock. Address 0x04 returns live bits 18:11.
- R2: A read strobe at 0x04 stores counter bits 10:0 into a snapshot. Address 0x05 returns snapshot bits 10:3. Address 0x03 returns snapshot bits 2:0 in bits 2:0, with the upper bits zero. The snapshot keeps its value until the next read strobe at 0x04.
- R3: The compare registers for channels 0–3 sit at 0x08/0x09, 0x0A/0x0B, 0x0C/0x0D and 0x0E/0x0F. In each pair the high byte is at the even address. Each byte is written and read back on its own.
- R4: Channel i detects a match when counter bits 2:0 are zero and bits 18:3 equal its compare value. Its flag is set on the next clock edge, which makes it visible one cycle after the counter reaches compare×8. This happens once per match.
- R5: Each capture input passes through two flip-flops before edge detection. A capture stores counter bits 18:3 as they stand after the second synchroniser edge.
- R6: For inputs 0 and 1, rising edges load one register and falling edges load another. The rise register is at 0x10/0x11 (input 0) and 0x14/0x15 (input 1). The fall register is at 0x12/0x13 (input 0) and 0x16/0x17 (input 1). An edge of one polarity never disturbs the other register.
- R7: The edge-select register is at 0x24. Bit 0 enables rising edges and bit 1 enables falling edges for input 2. Bits 2 and 3 do the same for input 3. Inputs 2 and 3 load 0x18/0x19 and 0x1A/0x1B. An edge that is not enabled changes neither the register nor the flag.
- R8: The flag register is at 0x1D. Bits 3:0 are the compare flags and bits 7:4 are the capture flags for inputs 0–3, also driven on `cmp_flag` and `cap_flag`. Writing 1 clears a bit and writing 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R9: Address 0x29 returns the synchronised input levels in bits 3:0, with the upper bits zero. A change on an input shows there two clocks after it is applied.
- R10: Reset clears the compare values, the capture values and the flags, and sets the edge-select register to 0x0F. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives the snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| cap_in | input | 4 | Asynchronous capture inputs |
| cmp_flag | output | 4 | Sticky compare-match flags |
| cap_flag | output | 4 | Sticky capture flags |

## Verification
The bench reassembles the three counter bytes and compares them with a counter model that it runs in lock-step. A snapshot that missed a bit, or that followed the live counter, would show up as a torn or moving value. A compare match is sampled both the cycle before and the cycle after the counter reaches compare×8. A comparator that ignored bits 2:0 or added an extra register would fire in the wrong cycle. Capture stamps are predicted from the two-flop latency, so a missing or extra synchroniser stage gives a stamp that is off by one. Disabled edges, opposite-polarity edges and writes of 0 to the flag register are each followed by a read of the state they might have corrupted.

// File: rtl/tmr_pkg.sv
// Package: shared widths and register addresses for the timer/capture unit.
// Assumes a 6-bit byte address space and exactly four compare and four capture channels.
package tmr_pkg;
    localparam int TMR_W    = 19;
    localparam int STAMP_W  = 16;
    localparam int BYTE_W   = 8;
    localparam int FRAC_W   = TMR_W - STAMP_W;
    localparam int SNAP_W   = TMR_W - BYTE_W;
    localparam int N_CMP    = 4;
    localparam int N_IN     = 4;
    localparam int N_DUAL   = 2;
    localparam int N_CAPREG = 2 * N_DUAL + (N_IN - N_DUAL);
    localparam int ADDR_W   = 6;

    localparam logic [ADDR_W-1:0] A_TMR_FRAC = 6'h03;
    localparam logic [ADDR_W-1:0] A_TMR_HI   = 6'h04;
    localparam logic [ADDR_W-1:0] A_TMR_MID  = 6'h05;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 6'h08;
    localparam logic [ADDR_W-1:0] A_CAP_BASE = 6'h10;
    localparam logic [ADDR_W-1:0] A_FLAGS    = 6'h1D;
    localparam logic [ADDR_W-1:0] A_EDGESEL  = 6'h24;
    localparam logic [ADDR_W-1:0] A_PINS     = 6'h29;
endpackage

// File: rtl/tmr_free_cnt.sv
// Free-running counter with a snapshot of its low bits.
// The snapshot is taken when snap_req is high; between requests it holds its value.
module tmr_free_cnt #(
    parameter int CNT_W  = 19,
    parameter int SNAP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_req,
    output logic [CNT_W-1:0]  count,
    output logic [SNAP_W-1:0] snap
);
    // Counter: clears on reset, otherwise steps by one each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    // Snapshot: freezes the low bits when the top byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap <= '0;
        else if (snap_req) snap <= count[SNAP_W-1:0];
    end

    p_tmr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count == CNT_W'($past(count) + 1'b1));
    p_snap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap));
    p_snap_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> snap == $past(count[SNAP_W-1:0]));
endmodule

// File: rtl/tmr_edge_sync.sv
// Two-flop synchroniser with edge detection for a vector of asynchronous inputs.
// Assumes each input holds a level for at least two clocks. Edges are reported one clock wide.
module tmr_edge_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    // Synchroniser chain plus a delayed copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge pulses from the synchronised level and its delayed copy.
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end

    p_sync_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> level == $past(meta_q));
endmodule

// File: rtl/tmr_cap_reg.sv
// One capture register: loads the timestamp when enabled and holds it otherwise.
module tmr_cap_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] stamp,
    output logic [W-1:0] value
);
    // Capture storage.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= stamp;
    end

    p_cap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> value == $past(stamp));
    p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(value));
endmodule

// File: rtl/tmr_cmp_chan.sv
// One compare channel: a byte-writable compare value and a single-cycle match pulse.
// Matches only on the first sub-count (low FRAC bits zero), so each match is reported once.
module tmr_cmp_chan #(
    parameter int CNT_W = 19,
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] count,
    output logic [CMP_W-1:0] cmp_val,
    output logic             hit
);
    localparam int FRAC = CNT_W - CMP_W;

    // Compare value: each byte written on its own.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_val <= '0;
        else begin
            if (wr_hi) cmp_val[CMP_W-1 -: 8] <= wdata;
            if (wr_lo) cmp_val[7:0]          <= wdata;
        end
    end

    // Match pulse on the first count of the matching window.
    always_comb hit = (count[FRAC-1:0] == '0) && (count[CNT_W-1:FRAC] == cmp_val);

    p_hit_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/tmr_cap_unit.sv
// Timer with four compare channels and four capture inputs, on a byte register bus.
// Reads are combinational on bus_addr. Writes and snapshots happen on the clock edge.
// Assumes the package address map and channel counts.
module tmr_cap_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [N_IN-1:0]   cap_in,
    output logic [N_CMP-1:0]  cmp_flag,
    output logic [N_IN-1:0]   cap_flag
);
    localparam int N_SINGLE = N_IN - N_DUAL;

    logic [TMR_W-1:0]   count;
    logic [SNAP_W-1:0]  snap;
    logic [N_IN-1:0]    lvl, rise, fall;
    logic [N_CMP-1:0]   cmp_hit;
    logic [STAMP_W-1:0] cmp_val [N_CMP];
    logic [STAMP_W-1:0] cap_val [N_CAPREG];
    logic [N_CAPREG-1:0] cap_load;
    logic [N_IN-1:0]    cap_set;
    logic [2*N_SINGLE-1:0] edge_sel;
    logic [N_CMP+N_IN-1:0] flags, flag_set, flag_clr;
    logic snap_req;

    assign snap_req = bus_rd && (bus_addr == A_TMR_HI);

    tmr_free_cnt #(.CNT_W(TMR_W), .SNAP_W(SNAP_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .count(count), .snap(snap));

    tmr_edge_sync #(.N(N_IN)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(cap_in),
        .level(lvl), .rise(rise), .fall(fall));

    for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
        tmr_cmp_chan #(.CNT_W(TMR_W), .CMP_W(STAMP_W)) cmp_i (
            .clk(clk), .rst_n(rst_n),
            .wr_hi(bus_wr && bus_addr == A_CMP_BASE + ADDR_W'(2*c)),
            .wr_lo(bus_wr && bus_addr == A_CMP_BASE + ADDR_W'(2*c+1)),
            .wdata(bus_wdata), .count(count),
            .cmp_val(cmp_val[c]), .hit(cmp_hit[c]));
    end

    // Capture registers: rise/fall pairs first, then one per single-register input.
    for (genvar k = 0; k < N_CAPREG; k++) begin : g_cap
        if (k < 2 * N_DUAL) begin : g_dual
            if (k % 2 == 0) begin : g_r
                assign cap_load[k] = rise[k/2];
            end else begin : g_f
                assign cap_load[k] = fall[k/2];
            end
        end else begin : g_single
            localparam int CH = k - N_DUAL;
            localparam int SI = k - 2 * N_DUAL;
            assign cap_load[k] = (rise[CH] & edge_sel[2*SI]) | (fall[CH] & edge_sel[2*SI+1]);
        end
        tmr_cap_reg #(.W(STAMP_W)) reg_i (
            .clk(clk), .rst_n(rst_n), .load(cap_load[k]),
            .stamp(count[TMR_W-1:FRAC_W]), .value(cap_val[k]));
    end

    // Per-input capture event, merged over that input's registers.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            if (i < N_DUAL) cap_set[i] = cap_load[2*i] | cap_load[2*i+1];
            else            cap_set[i] = cap_load[i + N_DUAL];
        end
    end

    // Edge-select register for the single-register inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_sel <= '1;
        else if (bus_wr && bus_addr == A_EDGESEL) edge_sel <= bus_wdata[2*N_SINGLE-1:0];
    end

    // Sticky flags: write-one-to-clear, with a set winning over a clear.
    assign flag_set = {cap_set, cmp_hit};
    assign flag_clr = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata : '0;
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | flag_set;
    end

    assign cmp_flag = flags[N_CMP-1:0];
    assign cap_flag = flags[N_CMP+N_IN-1:N_CMP];

    // Read-data multiplexer over the whole register map.
    always_comb begin
        logic [ADDR_W-1:0] off;
        bus_rdata = '0;
        off = '0;
        case (bus_addr)
            A_TMR_FRAC: bus_rdata = {(8-FRAC_W)'(0), snap[FRAC_W-1:0]};
            A_TMR_HI:   bus_rdata = count[TMR_W-1 -: 8];
            A_TMR_MID:  bus_rdata = snap[FRAC_W +: 8];
            A_FLAGS:    bus_rdata = flags;
            A_EDGESEL:  bus_rdata = {(8-2*N_SINGLE)'(0), edge_sel};
            A_PINS:     bus_rdata = {(8-N_IN)'(0), lvl};
            default:    ;
        endcase
        if (bus_addr >= A_CMP_BASE && bus_addr < A_CMP_BASE + ADDR_W'(2*N_CMP)) begin
            off = bus_addr - A_CMP_BASE;
            bus_rdata = off[0] ? cmp_val[off[2:1]][7:0] : cmp_val[off[2:1]][STAMP_W-1 -: 8];
        end
        if (bus_addr >= A_CAP_BASE && bus_addr < A_CAP_BASE + ADDR_W'(2*N_CAPREG)) begin
            off = bus_addr - A_CAP_BASE;
            bus_rdata = off[0] ? cap_val[off[3:1]][7:0] : cap_val[off[3:1]][STAMP_W-1 -: 8];
        end
    end

    for (genvar f = 0; f < N_CMP + N_IN; f++) begin : g_flag_chk
        p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            flag_set[f] |=> flags[f]);
        p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[f] && !flag_set[f]) |=> !flags[f]);
        p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_clr[f] && flags[f]) |=> flags[f]);
    end
    p_cmp_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit[0] |=> cmp_flag[0]);
endmodule

// File: tb/tmr_cap_unit_tb_top.sv
module tmr_cap_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] cap_in = '0;
    logic [3:0] cmp_flag, cap_flag;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [18:0] ref_cnt;

    always #4 clk = ~clk;

    tmr_cap_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .cmp_flag(cmp_flag), .cap_flag(cap_flag));

    // Counter model derived from R1.
    always @(posedge clk) begin
        if (!rst_n) ref_cnt <= '0;
        else        ref_cnt <= ref_cnt + 1'b1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd16(input logic [5:0] a, output logic [15:0] v);
        logic [7:0] h, l;
        rd(a, h); rd(a + 6'd1, l);
        v = {h, l};
    endtask

    // Drive one input at a negedge and return the stamp predicted by R5.
    task automatic drive(input int ch, input logic val, output logic [15:0] stamp);
        @(negedge clk);
        cap_in[ch] = val;
        @(posedge clk); @(posedge clk);
        #1 stamp = ref_cnt[18:3];
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(6'h1D, d); check("R10 flags", d, 0);
        rd(6'h24, d); check("R10 edge-select", d, 8'h0F);
        rd(6'h0A, d); check("R10 compare", d, 0);
        rd(6'h12, d); check("R10 capture", d, 0);
        rd(6'h1E, d); check("R10 unmapped", d, 0);
    endtask

    task automatic t_timer;
        logic [7:0] h, m, f, m2;
        logic [18:0] exp;
        @(negedge clk);
        bus_addr = 6'h04; bus_rd = 1'b1;
        #1 h = bus_rdata; exp = ref_cnt;
        @(negedge clk); bus_rd = 1'b0;
        check("R1 high byte", h, exp[18:11]);
        rd(6'h05, m); check("R2 middle byte", m, exp[10:3]);
        rd(6'h03, f); check("R2 low bits", f, exp[2:0]);
        repeat (37) @(negedge clk);
        rd(6'h05, m2); check("R2 snapshot holds", m2, exp[10:3]);
    endtask

    task automatic t_cmp_regs;
        logic [7:0] d;
        wr(6'h0C, 8'hA5); wr(6'h0D, 8'h3C);
        rd(6'h0C, d); check("R3 cmp2 high", d, 8'hA5);
        rd(6'h0D, d); check("R3 cmp2 low", d, 8'h3C);
        rd(6'h0E, d); check("R3 cmp3 untouched", d, 0);
    endtask

    task automatic t_cmp_match;
        logic [15:0] k;
        k = 16'(ref_cnt[18:3] + 16'd12);
        wr(6'h08, k[15:8]); wr(6'h09, k[7:0]);
        wr(6'h1D, 8'h0F);
        @(negedge clk);
        check("R8 cleared before match", cmp_flag[0], 0);
        while (ref_cnt != {k, 3'b000}) @(negedge clk);
        check("R4 no flag before match", cmp_flag[0], 0);
        @(negedge clk);
        check("R4 flag after match", cmp_flag[0], 1);
        wr(6'h1D, 8'h0E);
        check("R8 write 0 keeps flag", cmp_flag[0], 1);
        wr(6'h1D, 8'h01);
        check("R8 write 1 clears flag", cmp_flag[0], 0);
    endtask

    task automatic t_cap_dual;
        logic [15:0] er, ef, v;
        wr(6'h1D, 8'hF0);
        drive(0, 1'b1, er);
        rd16(6'h10, v); check("R6 in0 rise value", v, er);
        rd16(6'h12, v); check("R6 in0 fall untouched", v, 0);
        check("R8 cap flag 0", cap_flag, 4'b0001);
        repeat (20) @(negedge clk);
        drive(0, 1'b0, ef);
        rd16(6'h12, v); check("R5 in0 fall value", v, ef);
        rd16(6'h10, v); check("R6 in0 rise kept", v, er);
        drive(1, 1'b1, er);
        rd16(6'h14, v); check("R6 in1 rise value", v, er);
    endtask

    task automatic t_cap_select;
        logic [15:0] e, v, junk;
        wr(6'h24, 8'h02);
        wr(6'h1D, 8'hF0);
        drive(2, 1'b1, junk);
        check("R7 disabled edge no flag", cap_flag[2], 0);
        rd16(6'h18, v); check("R7 disabled edge no load", v, 0);
        drive(2, 1'b0, e);
        rd16(6'h18, v); check("R7 falling edge load", v, e);
        check("R7 flag on enabled edge", cap_flag[2], 1);
        wr(6'h24, 8'h0C);
        drive(3, 1'b1, e);
        rd16(6'h1A, v); check("R7 in3 rise", v, e);
        drive(3, 1'b0, e);
        rd16(6'h1A, v); check("R7 in3 fall", v, e);
    endtask

    task automatic t_pins;
        @(negedge clk);
        bus_addr = 6'h29;
        cap_in = 4'b0101;
        @(posedge clk); #1 check("R9 pins after one clock", bus_rdata, 8'h0A);
        @(posedge clk); #1 check("R9 pins after two clocks", bus_rdata, 8'h05);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wr(6'h1D, 8'hFF);
        t_timer();
        t_cmp_regs();
        t_cmp_match();
        t_cap_dual();
        cap_in[1] = 1'b1;
        t_cap_select();
        cap_in = 4'b1010;
        repeat (4) @(negedge clk);
        t_pins();
        t_timer();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule